// File: doc/BRIEF.md
# Transmit Start and Pause Gate

This block sits between a small transmit FIFO of three 64-byte cells and the MAC serialiser. It decides the cycle in which the next frame may begin on the wire, and which of eight transmit queues supplies that frame. A frame may start once a programmable number of whole cells is buffered, or earlier if the frame's last byte is already in the FIFO. The MAC reports a frame in flight through `frame_busy_i`, and no new start is issued while that signal is high.

In full duplex with transmit flow control switched on, a decoded pause request loads a 16-bit hold-off timer. The timer counts down once per slot tick, which marks 512 bit times. While the timer is non-zero, new starts are withheld. A frame that is already running is never cut short, because the gate acts only on starting the next frame. Queue selection is either fixed priority or round-robin, chosen by one mode input.

Top module: `tx_start_gate`

## Requirements
- R1: With a queue ready, `frame_busy_i` low and no hold-off, `start_o` pulses one cycle after the rising clock edge at which `cell_count_i` is greater than or equal to the effective threshold.
- R2: `eop_buffered_i` high permits a start whatever the cell count is.
- R3: The effective threshold is `cell_thresh_i` clamped to 1..3. A value of 0 acts as 1, and a value of 4 to 7 acts as 3.
- R4: With `rr_mode_i` = 0, the ready queue with the highest index is chosen, so queue 7 has the highest priority.
- R5: With `rr_mode_i` = 1, the chosen queue is the first ready queue after the last queue served, searching upward and wrapping. After reset, the last queue served is taken to be 7.
- R6: No start is issued while `frame_busy_i` is high. `start_o` never stays high for two cycles in a row.
- R7: When `pause_valid_i` is high with `full_duplex_i` and `flow_en_i` both high, `pause_timer_o` takes `pause_quanta_i` at the next edge, and this overrides any count in progress. `pause_hold_o` is high while the timer is non-zero and both enables are high, and no start is issued while it is high.
- R8: A pause request made while `full_duplex_i` or `flow_en_i` is low leaves `pause_timer_o` unchanged.
- R9: Each `slot_tick_i` lowers a non-zero timer by one. A request with zero quanta clears the timer and the hold at the next edge.
- R10: After reset, `start_o`, `pause_timer_o` and `pause_hold_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| q_ready_i | input | 8 | Per-queue frame-ready flags |
| rr_mode_i | input | 1 | 0 = fixed priority, 1 = round-robin |
| cell_count_i | input | 2 | Number of full 64-byte cells buffered (0..3) |
| eop_buffered_i | input | 1 | End of the current frame is in the FIFO |
| cell_thresh_i | input | 3 | Start threshold in cells, before clamping |
| frame_busy_i | input | 1 | MAC is sending a frame |
| full_duplex_i | input | 1 | Full-duplex mode |
| flow_en_i | input | 1 | Act on received pause requests |
| pause_valid_i | input | 1 | Decoded pause request strobe |
| pause_quanta_i | input | 16 | Pause time in slot units |
| slot_tick_i | input | 1 | One pulse per 512 bit times |
| start_o | output | 1 | One-cycle frame start pulse |
| start_queue_o | output | 3 | Queue chosen for the start |
| pause_timer_o | output | 16 | Remaining pause time |
| pause_hold_o | output | 1 | New starts are being withheld |

## Verification
The assertions assume that the MAC raises `frame_busy_i` soon after a start, and that `cell_count_i` never exceeds three. They also assume that `pause_valid_i` and `slot_tick_i` are single-cycle strobes driven by synchronous logic. The stimulus changes every input only at the falling edge. It raises the busy flag right after each observed start and clears the ready flags before it releases that flag, so each start is accounted for exactly once. Pause loads are made while busy is high, so that a load and a start never land on the same edge.

// File: rtl/tsg_pkg.sv
package tsg_pkg;
  typedef enum logic {
    ARB_FIXED = 1'b0,
    ARB_RR    = 1'b1
  } arb_mode_e;

  localparam int PAUSE_W = 16;
endpackage

// File: rtl/tsg_start_cond.sv
module tsg_start_cond #(
  parameter int MAX_CELLS = 3,
  parameter int CNT_W     = 2,
  parameter int THR_W     = 3
) (
  input  logic [CNT_W-1:0] cell_count_i,
  input  logic             eop_buffered_i,
  input  logic [THR_W-1:0] cell_thresh_i,
  output logic             fill_ok_o
);
  logic [THR_W-1:0] thr_eff;

  // clamp the programmed threshold into 1..MAX_CELLS
  always_comb begin
    if (cell_thresh_i == '0)
      thr_eff = THR_W'(1);
    else if (int'(cell_thresh_i) > MAX_CELLS)
      thr_eff = THR_W'(MAX_CELLS);
    else
      thr_eff = cell_thresh_i;
  end

  assign fill_ok_o = eop_buffered_i ||
                     (int'(cell_count_i) >= int'(thr_eff));
endmodule

// File: rtl/tsg_arbiter.sv
module tsg_arbiter #(
  parameter int NUM_Q = 8,
  localparam int QW   = $clog2(NUM_Q)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NUM_Q-1:0] req_i,
  input  logic             rr_mode_i,
  input  logic             take_i,
  output logic             grant_valid_o,
  output logic [QW-1:0]    grant_idx_o
);
  import tsg_pkg::*;

  logic [QW-1:0] last_q, last_d;
  logic [QW-1:0] fixed_idx, rr_idx;
  arb_mode_e     mode;

  assign mode = arb_mode_e'(rr_mode_i);

  // fixed priority: highest index wins
  always_comb begin
    fixed_idx = '0;
    for (int i = 0; i < NUM_Q; i++)
      if (req_i[i]) fixed_idx = QW'(i);
  end

  // round-robin: smallest offset after the last served wins
  always_comb begin
    rr_idx = '0;
    for (int k = NUM_Q; k >= 1; k--) begin
      if (req_i[(int'(last_q) + k) % NUM_Q])
        rr_idx = QW'((int'(last_q) + k) % NUM_Q);
    end
  end

  assign grant_valid_o = |req_i;
  assign grant_idx_o   = (mode == ARB_RR) ? rr_idx : fixed_idx;

  always_comb begin
    last_d = last_q;
    if (take_i) last_d = grant_idx_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= QW'(NUM_Q - 1);
    else        last_q <= last_d;
  end
endmodule

// File: rtl/tsg_pause_timer.sv
module tsg_pause_timer #(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable_i,
  input  logic          load_i,
  input  logic [PW-1:0] quanta_i,
  input  logic          tick_i,
  output logic [PW-1:0] timer_o
);
  logic [PW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i && enable_i)
      cnt_d = quanta_i;
    else if (tick_i && (cnt_q != '0))
      cnt_d = cnt_q - PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign timer_o = cnt_q;
endmodule

// File: rtl/tx_start_gate.sv
module tx_start_gate #(
  parameter int NUM_Q     = 8,
  parameter int MAX_CELLS = 3,
  parameter int THR_W     = 3,
  localparam int QW       = $clog2(NUM_Q),
  localparam int CNT_W    = $clog2(MAX_CELLS + 1),
  localparam int PW       = tsg_pkg::PAUSE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NUM_Q-1:0] q_ready_i,
  input  logic             rr_mode_i,
  input  logic [CNT_W-1:0] cell_count_i,
  input  logic             eop_buffered_i,
  input  logic [THR_W-1:0] cell_thresh_i,
  input  logic             frame_busy_i,
  input  logic             full_duplex_i,
  input  logic             flow_en_i,
  input  logic             pause_valid_i,
  input  logic [PW-1:0]    pause_quanta_i,
  input  logic             slot_tick_i,
  output logic             start_o,
  output logic [QW-1:0]    start_queue_o,
  output logic [PW-1:0]    pause_timer_o,
  output logic             pause_hold_o
);
  logic          fill_ok, grant_valid, start_d, start_q, flow_on;
  logic [QW-1:0] grant_idx, queue_d, queue_q;

  tsg_start_cond #(.MAX_CELLS(MAX_CELLS), .CNT_W(CNT_W), .THR_W(THR_W)) u_cond (
    .cell_count_i   (cell_count_i),
    .eop_buffered_i (eop_buffered_i),
    .cell_thresh_i  (cell_thresh_i),
    .fill_ok_o      (fill_ok)
  );

  tsg_arbiter #(.NUM_Q(NUM_Q)) u_arb (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_i         (q_ready_i),
    .rr_mode_i     (rr_mode_i),
    .take_i        (start_d),
    .grant_valid_o (grant_valid),
    .grant_idx_o   (grant_idx)
  );

  assign flow_on = full_duplex_i && flow_en_i;

  tsg_pause_timer #(.PW(PW)) u_pause (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable_i (flow_on),
    .load_i   (pause_valid_i),
    .quanta_i (pause_quanta_i),
    .tick_i   (slot_tick_i),
    .timer_o  (pause_timer_o)
  );

  assign pause_hold_o = flow_on && (pause_timer_o != '0);

  always_comb begin
    start_d = grant_valid && fill_ok && !frame_busy_i &&
              !pause_hold_o && !start_q;
    queue_d = start_d ? grant_idx : queue_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      queue_q <= '0;
    end else begin
      start_q <= start_d;
      queue_q <= queue_d;
    end
  end

  assign start_o       = start_q;
  assign start_queue_o = queue_q;
endmodule

// File: rtl/tx_start_gate_chk.sv
module tx_start_gate_chk #(
  parameter int NUM_Q     = 8,
  parameter int MAX_CELLS = 3,
  parameter int THR_W     = 3,
  parameter int QW        = 3,
  parameter int CNT_W     = 2,
  parameter int PW        = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NUM_Q-1:0] q_ready_i,
  input logic [CNT_W-1:0] cell_count_i,
  input logic             eop_buffered_i,
  input logic [THR_W-1:0] cell_thresh_i,
  input logic             frame_busy_i,
  input logic             full_duplex_i,
  input logic             flow_en_i,
  input logic             pause_valid_i,
  input logic [PW-1:0]    pause_quanta_i,
  input logic             slot_tick_i,
  input logic             start_o,
  input logic [QW-1:0]    start_queue_o,
  input logic [PW-1:0]    pause_timer_o,
  input logic             pause_hold_o
);
  logic enough;
  assign enough = eop_buffered_i ||
    (int'(cell_count_i) >= ((cell_thresh_i == '0) ? 1 :
      ((int'(cell_thresh_i) > MAX_CELLS) ? MAX_CELLS : int'(cell_thresh_i))));

  AST_START_NEEDS_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> $past(enough)); // R1

  AST_START_QUEUE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> (($past(q_ready_i) >> start_queue_o) & 1) != 0); // R4

  AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> !$past(frame_busy_i)); // R6

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> !start_o); // R6

  AST_NO_START_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> !$past(pause_hold_o)); // R7

  AST_PAUSE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (pause_valid_i && full_duplex_i && flow_en_i) |=>
      pause_timer_o == $past(pause_quanta_i)); // R7

  AST_PAUSE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (pause_valid_i && !(full_duplex_i && flow_en_i) && !slot_tick_i) |=>
      $stable(pause_timer_o)); // R8

  AST_PAUSE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!pause_valid_i && slot_tick_i && pause_timer_o != '0) |=>
      pause_timer_o == $past(pause_timer_o) - PW'(1)); // R9
endmodule

bind tx_start_gate tx_start_gate_chk #(
  .NUM_Q(NUM_Q), .MAX_CELLS(MAX_CELLS), .THR_W(THR_W),
  .QW(QW), .CNT_W(CNT_W), .PW(PW)
) chk_i (
  .clk(clk), .rst_n(rst_n), .q_ready_i(q_ready_i),
  .cell_count_i(cell_count_i), .eop_buffered_i(eop_buffered_i),
  .cell_thresh_i(cell_thresh_i), .frame_busy_i(frame_busy_i),
  .full_duplex_i(full_duplex_i), .flow_en_i(flow_en_i),
  .pause_valid_i(pause_valid_i), .pause_quanta_i(pause_quanta_i),
  .slot_tick_i(slot_tick_i), .start_o(start_o),
  .start_queue_o(start_queue_o), .pause_timer_o(pause_timer_o),
  .pause_hold_o(pause_hold_o)
);

// File: tb/tx_start_gate_tb_top.sv
module tx_start_gate_tb_top;
  logic        clk, rst_n;
  logic [7:0]  q_ready;
  logic        rr_mode, eop, busy, fd, fe, pv, tick;
  logic [1:0]  cells;
  logic [2:0]  thr;
  logic [15:0] quanta;
  logic        start;
  logic [2:0]  sq;
  logic [15:0] ptimer;
  logic        hold;
  int          n_chk = 0, n_err = 0;

  tx_start_gate dut_i (
    .clk(clk), .rst_n(rst_n), .q_ready_i(q_ready), .rr_mode_i(rr_mode),
    .cell_count_i(cells), .eop_buffered_i(eop), .cell_thresh_i(thr),
    .frame_busy_i(busy), .full_duplex_i(fd), .flow_en_i(fe),
    .pause_valid_i(pv), .pause_quanta_i(quanta), .slot_tick_i(tick),
    .start_o(start), .start_queue_o(sq), .pause_timer_o(ptimer),
    .pause_hold_o(hold)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // leave the gate quiet: nothing ready, MAC idle
  task automatic quiet();
    q_ready = '0; busy = 1'b0; eop = 1'b0; cells = '0; pv = 1'b0; tick = 1'b0;
    step();
  endtask

  task automatic t_reset();
    chk("R10 start", int'(start), 0);
    chk("R10 timer", int'(ptimer), 0);
    chk("R10 hold", int'(hold), 0);
  endtask

  task automatic t_threshold();
    rr_mode = 1'b0; thr = 3'd2; q_ready = 8'h08; cells = 2'd1;
    step(); chk("R1 below threshold", int'(start), 0);
    cells = 2'd2;
    step(); chk("R1 at threshold", int'(start), 1);
    chk("R1 queue", int'(sq), 3);
    busy = 1'b1; quiet();
  endtask

  task automatic t_eop();
    thr = 3'd3; q_ready = 8'h01; cells = 2'd0; eop = 1'b1;
    step(); chk("R2 eop start", int'(start), 1);
    busy = 1'b1; quiet();
  endtask

  task automatic t_clamp();
    thr = 3'd0; q_ready = 8'h01; cells = 2'd0;
    step(); chk("R3 zero thr, no cells", int'(start), 0);
    cells = 2'd1;
    step(); chk("R3 zero thr acts as 1", int'(start), 1);
    busy = 1'b1; quiet();
    thr = 3'd7; q_ready = 8'h01; cells = 2'd2;
    step(); chk("R3 thr 7, two cells", int'(start), 0);
    cells = 2'd3;
    step(); chk("R3 thr 7 acts as 3", int'(start), 1);
    busy = 1'b1; quiet();
  endtask

  task automatic t_busy_pulse();
    thr = 3'd1; cells = 2'd3; q_ready = 8'h01; busy = 1'b1;
    for (int i = 0; i < 3; i++) begin
      step(); chk("R6 busy blocks", int'(start), 0);
    end
    busy = 1'b0;
    step(); chk("R6 start after busy", int'(start), 1);
    step(); chk("R6 single pulse", int'(start), 0);
    busy = 1'b1; quiet();
  endtask

  task automatic t_fixed();
    rr_mode = 1'b0; thr = 3'd1; cells = 2'd3; q_ready = 8'b0010_0110;
    step(); chk("R4 fixed highest", int'(sq), 5);
    chk("R4 start", int'(start), 1);
    busy = 1'b1; quiet();
  endtask

  task automatic t_rr();
    rr_mode = 1'b1; thr = 3'd1; cells = 2'd3; q_ready = 8'b0010_0100;
    step(); chk("R5 rr after 5 wraps to 2", int'(sq), 2);
    busy = 1'b1; quiet();
    q_ready = 8'b0010_0100; cells = 2'd3;
    step(); chk("R5 rr after 2 gives 5", int'(sq), 5);
    busy = 1'b1; quiet();
    q_ready = 8'b0010_0000; cells = 2'd3;
    step(); chk("R5 rr same queue again", int'(sq), 5);
    busy = 1'b1; quiet();
  endtask

  task automatic t_pause();
    fd = 1'b1; fe = 1'b1; busy = 1'b1; pv = 1'b1; quanta = 16'd3;
    step(); pv = 1'b0;
    chk("R7 timer loaded", int'(ptimer), 3);
    chk("R7 hold on", int'(hold), 1);
    busy = 1'b0; q_ready = 8'h01; cells = 2'd3; thr = 3'd1;
    step(); chk("R7 hold blocks start", int'(start), 0);
    tick = 1'b1;
    step(); chk("R9 tick 1", int'(ptimer), 2);
    chk("R7 still blocked", int'(start), 0);
    step(); step(); tick = 1'b0;
    chk("R9 reached zero", int'(ptimer), 0);
    chk("R9 hold off", int'(hold), 0);
    step(); chk("R7 start after expiry", int'(start), 1);
    busy = 1'b1; quiet();
    busy = 1'b1; pv = 1'b1; quanta = 16'd5;
    step(); quanta = 16'd2;
    step(); pv = 1'b0;
    chk("R9 reload", int'(ptimer), 2);
    pv = 1'b1; quanta = 16'd0;
    step(); pv = 1'b0;
    chk("R9 zero quanta clears", int'(ptimer), 0);
    chk("R9 zero quanta hold", int'(hold), 0);
  endtask

  task automatic t_ignore();
    fd = 1'b0; fe = 1'b1; busy = 1'b1; pv = 1'b1; quanta = 16'd9;
    step(); pv = 1'b0;
    chk("R8 half duplex ignored", int'(ptimer), 0);
    fd = 1'b1; fe = 1'b0; pv = 1'b1;
    step(); pv = 1'b0;
    chk("R8 flow off ignored", int'(ptimer), 0);
    chk("R8 no hold", int'(hold), 0);
    quiet();
  endtask

  initial begin
    rst_n = 1'b0; q_ready = '0; rr_mode = 1'b0; cells = '0; eop = 1'b0;
    thr = 3'd1; busy = 1'b0; fd = 1'b0; fe = 1'b0; pv = 1'b0;
    quanta = '0; tick = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    step();
    t_reset();
    t_threshold();
    t_eop();
    t_clamp();
    t_busy_pulse();
    t_fixed();
    t_rr();
    t_pause();
    t_ignore();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule